// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the serial management bus of Ethernet PHYs. Software sees two 16-bit registers. The data register holds the word to send, or the word that came back. The command register holds a 5-bit PHY address, a 5-bit register address and two request flags, one for read and one for write. When a request flag is written as one, the block sends a complete management frame on the MDC clock and MDIO data pins. The flag stays set while the frame is on the wire and clears by itself when the frame ends, so software finds out that a transaction is done by polling that flag.

A write frame carries the data register contents, which software loads before it issues the command. A read frame releases MDIO at the turnaround and shifts in sixteen bits from the PHY. The result lands in the data register in the same cycle the flag clears. MDC is made from the system clock by an even divider parameter. The line idles low, and MDC only runs while a frame is in progress.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the command register and the data register both read 0, MDC is low and the MDIO output enable is low.
- R2: A command with bit 1 (write) set and bit 0 clear sends 64 MDC periods with the output enable high throughout, MSB first: 32 ones, start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 data register bits. Afterwards the data register still holds the sent word.
- R3: A command with bit 0 (read) set sends 32 ones, start 01, opcode 10, PHY address and register address with the output enable high. The enable is low for the remaining 18 periods (turnaround and data).
- R4: After a read completes, the data register (offset 4) holds the 16 bits sampled on MDIO at the rising MDC edges of the last 16 periods, MSB first. With MDIO held high (no PHY present) it reads 0xFFFF.
- R5: The command register (offset 0) reads back the PHY address in bits 13:9 and the register address in bits 8:4, with bits 3:2 zero. The accepted request flag reads as one for exactly 64×DIV clock cycles from the accepting write and then reads zero.
- R6: MDC is low whenever no frame is in progress. During a frame, rising edges are DIV clock cycles apart and each high phase lasts DIV/2 cycles.
- R7: A command with both bits 0 and 1 set performs a read. Bit 1 reads back as zero during that read.
- R8: A command write that arrives while a request flag is set is ignored: the frame in progress is unchanged, the address fields keep their values, and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register select: 0 command, 4 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register selected by reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | MDIO pad input, pulled high when nothing drives it |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions take it that reg_addr holds only 0 or 4 whenever reg_wr is high, that reg_wr never stays high for more than one cycle per access, and that DIV is even and at least 4. The stimulus writes only those two offsets, each through a task that raises the strobe for a single cycle. A PHY model answers on falling MDC edges and otherwise leaves MDIO at its pulled-up level. The one mid-frame command is injected deliberately, to exercise the ignore rule.

// File: rtl/mdio_pkg.sv
// mdio_pkg: field positions, register offsets and frame constants shared by
// the management master. Assumes 5-bit PHY and register addresses.
package mdio_pkg;
    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int DATA_W  = 16;
    localparam int PRE_LEN = 32;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    localparam logic [2:0] CMD_OFS  = 3'h0;
    localparam logic [2:0] DATA_OFS = 3'h4;

    localparam int RD_BIT  = 0;
    localparam int WR_BIT  = 1;
    localparam int REG_LSB = 4;
    localparam int PHY_LSB = 9;
endpackage

// File: rtl/mdio_clk_gen.sv
// mdio_clk_gen: divides clk by DIV into MDC while run is high. It flags the
// cycle in which MDC rises (sample point) and the last cycle of each bit.
// Assumes DIV is even and >= 4. MDC is held low while run is low.
module mdio_clk_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic bit_end
);
    localparam int CW = $clog2(DIV);
    localparam int HALF = DIV / 2;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] HALF_C  = CW'(HALF);
    localparam logic [CW-1:0] LAST_C  = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign rise_tick = run && (cnt_q == HALF_M1);
    assign bit_end   = run && (cnt_q == LAST_C);

    // Phase counter within one MDC period; parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || bit_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // MDC level: high for the second half of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            mdc <= 1'b0;
        else if (rise_tick)
            mdc <= 1'b1;
        else if (bit_end)
            mdc <= 1'b0;
    end

    assert_mdc_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);
    assert_mdc_rise_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (cnt_q == HALF_C));
endmodule

// File: rtl/mdio_frame_engine.sv
// mdio_frame_engine: builds one management frame on start and shifts it out
// MSB first, one bit per MDC period. For reads it releases MDIO from the
// turnaround on and collects the data bits at the rising MDC edge.
// Assumes start is only asserted while the engine is idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_tick,
    input  logic              bit_end,
    input  logic              mdio_in,
    output logic              active,
    output logic              finish,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rx_data
);
    localparam int TA_POS   = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int DATA_POS = TA_POS + 2;
    localparam int FRAME    = DATA_POS + DATA_W;
    localparam int IW       = $clog2(FRAME);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME - 1);

    logic [FRAME-1:0] frame_q;
    logic [FRAME-1:0] frame_d;
    logic [IW-1:0]    idx_q;
    logic             rd_q;

    // Frame image for the requested operation.
    always_comb begin
        frame_d = {{PRE_LEN{1'b1}}, SOF_CODE, (start_rd ? OP_READ : OP_WRITE),
                   phy, regad, (start_rd ? 2'b00 : TA_DRIVE),
                   (start_rd ? {DATA_W{1'b0}} : wdata)};
    end

    assign finish   = active && bit_end && (idx_q == LAST_IDX);
    assign mdio_out = frame_q[FRAME-1];

    // Sequencer: load, shift at each bit boundary, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            active  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (start && !active) begin
            frame_q <= frame_d;
            idx_q   <= '0;
            rd_q    <= start_rd;
            active  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (finish) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            frame_q <= '0;
        end else if (active && bit_end) begin
            frame_q <= frame_q << 1;
            idx_q   <= idx_q + 1'b1;
            mdio_oe <= !(rd_q && (int'(idx_q) + 1 >= TA_POS));
        end
    end

    // Read capture: shift in MDIO at the rising MDC edge of each data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_data <= '0;
        else if (active && rd_q && rise_tick && (int'(idx_q) >= DATA_POS))
            rx_data <= {rx_data[DATA_W-2:0], mdio_in};
    end

    assert_release_turnaround_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_q && (int'(idx_q) >= TA_POS)) |-> !mdio_oe);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_regs.sv
// mdio_cmd_regs: command and data registers. Accepts a command only while
// idle, raises the matching request flag (read wins over write), clears it
// on finish and stores read results. Assumes one-cycle reg_wr strobes.
module mdio_cmd_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              finish,
    input  logic [DATA_W-1:0] rx_data,
    output logic [15:0]       reg_rdata,
    output logic              start,
    output logic              start_rd,
    output logic [PHY_AW-1:0] tgt_phy,
    output logic [REG_AW-1:0] tgt_reg,
    output logic [DATA_W-1:0] wr_data
);
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] reg_q;
    logic              rd_busy_q;
    logic              wr_busy_q;
    logic              busy;
    logic              cmd_sel;
    logic              data_sel;

    assign busy     = rd_busy_q | wr_busy_q;
    assign cmd_sel  = reg_wr && (reg_addr == CMD_OFS);
    assign data_sel = reg_wr && (reg_addr == DATA_OFS);
    assign start    = cmd_sel && !busy && (reg_wdata[RD_BIT] | reg_wdata[WR_BIT]);
    assign start_rd = reg_wdata[RD_BIT];
    assign tgt_phy  = reg_wdata[PHY_LSB +: PHY_AW];
    assign tgt_reg  = reg_wdata[REG_LSB +: REG_AW];

    // Address fields: updated only by a command write while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
        end else if (cmd_sel && !busy) begin
            phy_q <= tgt_phy;
            reg_q <= tgt_reg;
        end
    end

    // Request flags: set on an accepted command, cleared on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_busy_q <= 1'b0;
            wr_busy_q <= 1'b0;
        end else if (finish) begin
            rd_busy_q <= 1'b0;
            wr_busy_q <= 1'b0;
        end else if (start) begin
            rd_busy_q <= start_rd;
            wr_busy_q <= !start_rd;
        end
    end

    // Data register: read result has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_data <= '0;
        else if (finish && rd_busy_q)
            wr_data <= rx_data;
        else if (data_sel)
            wr_data <= reg_wdata;
    end

    // Read-back mux for the selected register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CMD_OFS)
            reg_rdata = {2'b00, phy_q, reg_q, 2'b00, wr_busy_q, rd_busy_q};
        else if (reg_addr == DATA_OFS)
            reg_rdata = wr_data;
    end

    assert_single_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_busy_q, rd_busy_q}));
    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_sel && !finish) |=> ($stable({phy_q, reg_q}) && busy));
    assert_finish_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !(rd_busy_q || wr_busy_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// mdio_mgmt_ctrl: register-mapped MDIO management master. Connects the
// register block, the frame engine and the MDC divider. Assumes an external
// pull-up on MDIO and a tristate pad driven by mdio_out/mdio_oe.
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe
);
    logic              start;
    logic              start_rd;
    logic [PHY_AW-1:0] tgt_phy;
    logic [REG_AW-1:0] tgt_reg;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rx_data;
    logic              active;
    logic              finish;
    logic              rise_tick;
    logic              bit_end;

    mdio_cmd_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .finish(finish), .rx_data(rx_data),
        .reg_rdata(reg_rdata), .start(start), .start_rd(start_rd),
        .tgt_phy(tgt_phy), .tgt_reg(tgt_reg), .wr_data(wr_data)
    );

    mdio_frame_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .phy(tgt_phy), .regad(tgt_reg), .wdata(wr_data),
        .rise_tick(rise_tick), .bit_end(bit_end), .mdio_in(mdio_in),
        .active(active), .finish(finish), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .rx_data(rx_data)
    );

    mdio_clk_gen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(active), .mdc(mdc),
        .rise_tick(rise_tick), .bit_end(bit_end)
    );
endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;
    localparam int DIV = 32;
    localparam logic [2:0] A_CMD  = 3'h0;
    localparam logic [2:0] A_DATA = 3'h4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int tests = 0;
    int fails = 0;
    bit done_flag = 0;
    longint cyc = 0;

    // PHY model state
    int          n = 0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    logic [15:0] resp = '0;
    bit          present = 0;
    bit          model_rd = 0;
    int          bad_per = 0;
    longint      last_rise = 0;

    always #4 clk = ~clk;

    mdio_mgmt_ctrl #(.DIV(DIV)) u_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    always @(posedge clk) cyc++;

    always @(posedge mdc) begin
        cap   = {cap[62:0], mdio_out};
        oecap = {oecap[62:0], mdio_oe};
        if (n > 0 && (cyc - last_rise) != DIV) bad_per++;
        last_rise = cyc;
        n++;
        if (n == 36) model_rd = (cap[1:0] == 2'b10);
    end

    always @(negedge mdc) begin
        if ((cyc - last_rise) != DIV / 2) bad_per++;
        if (present && model_rd) begin
            if (n == 47) mdio_in = 1'b0;
            else if (n >= 48 && n <= 63) mdio_in = resp[63 - n];
            else if (n >= 64) mdio_in = 1'b1;
        end
    end

    function automatic logic [63:0] exp_wr_frame(input logic [4:0] p, input logic [4:0] r,
                                                 input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [45:0] exp_rd_head(input logic [4:0] p, input logic [4:0] r);
        return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    endfunction

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic arm();
        n = 0; cap = '0; oecap = '0; bad_per = 0; model_rd = 0; mdio_in = 1'b1;
    endtask

    task automatic wait_idle(output int cnt, output logic [15:0] first);
        logic [15:0] v;
        rd_reg(A_CMD, v);
        first = v;
        cnt = 0;
        while (v[1:0] != 2'b00 && cnt < 5000) begin
            cnt++;
            @(negedge clk);
            rd_reg(A_CMD, v);
        end
    endtask

    task automatic do_txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d, input logic [15:0] rsp, input bit pres);
        int cnt;
        logic [15:0] first, v;
        bit is_rd;
        is_rd = op[0];
        arm();
        resp = rsp; present = pres;
        wr_reg(A_DATA, d);
        wr_reg(A_CMD, {2'b00, p, r, 2'b00, op});
        wait_idle(cnt, first);
        check(cnt == 64 * DIV, "R5 busy length", 64'(cnt), 64'(64 * DIV));
        check(first[1:0] == (is_rd ? 2'b01 : 2'b10), "R5 R7 request flags while busy",
              64'(first[1:0]), 64'(is_rd ? 2'b01 : 2'b10));
        rd_reg(A_CMD, v);
        check(v == {2'b00, p, r, 4'b0000}, "R5 command readback", 64'(v),
              64'({2'b00, p, r, 4'b0000}));
        check(bad_per == 0 && n == 64, "R6 mdc timing and count", 64'(bad_per * 1000 + n), 64'(64));
        rd_reg(A_DATA, v);
        if (!is_rd) begin
            check(cap == exp_wr_frame(p, r, d), "R2 write frame", cap, exp_wr_frame(p, r, d));
            check(oecap == {64{1'b1}}, "R2 write enable", oecap, {64{1'b1}});
            check(v == d, "R2 data kept", 64'(v), 64'(d));
        end else begin
            check(cap[63:18] == exp_rd_head(p, r), "R3 read header", 64'(cap[63:18]),
                  64'(exp_rd_head(p, r)));
            check(oecap == {{46{1'b1}}, 18'b0}, "R3 read release", oecap, {{46{1'b1}}, 18'b0});
            check(v == (pres ? rsp : 16'hFFFF), "R4 read result", 64'(v),
                  64'(pres ? rsp : 16'hFFFF));
        end
    endtask

    initial begin
        #(8 * 200000);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        summary();
    end

    initial begin
        logic [15:0] v;
        int cnt;
        logic [15:0] first;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_reg(A_CMD, v);
        check(v == 16'h0, "R1 command after reset", 64'(v), 64'h0);
        rd_reg(A_DATA, v);
        check(v == 16'h0, "R1 data after reset", 64'(v), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", 64'({mdc, mdio_oe}), 64'h0);

        // Directed write, directed read, absent PHY, both bits set (R7)
        do_txn(2'b10, 5'h1F, 5'h00, 16'hA5C3, 16'h0000, 1'b1);
        do_txn(2'b01, 5'h01, 5'h02, 16'h1234, 16'h0141, 1'b1);
        do_txn(2'b01, 5'h07, 5'h1F, 16'h5555, 16'h0000, 1'b0);
        do_txn(2'b11, 5'h0A, 5'h15, 16'h0F0F, 16'hC003, 1'b1);

        // R8: command during busy ignored
        arm();
        resp = 16'h8E71; present = 1;
        wr_reg(A_CMD, {2'b00, 5'h03, 5'h07, 4'b0001});
        repeat (500) @(negedge clk);
        wr_reg(A_CMD, {2'b00, 5'h09, 5'h01, 4'b0010});
        wait_idle(cnt, first);
        check(cap[63:18] == exp_rd_head(5'h03, 5'h07), "R8 frame unchanged", 64'(cap[63:18]),
              64'(exp_rd_head(5'h03, 5'h07)));
        rd_reg(A_CMD, v);
        check(v == {2'b00, 5'h03, 5'h07, 4'b0000}, "R8 fields kept", 64'(v),
              64'({2'b00, 5'h03, 5'h07, 4'b0000}));
        repeat (4 * DIV) @(negedge clk);
        check(n == 64 && mdc == 1'b0, "R8 no extra frame", 64'(n), 64'(64));
        rd_reg(A_DATA, v);
        check(v == 16'h8E71, "R8 R4 read result", 64'(v), 64'h8E71);

        // Random transactions
        for (int i = 0; i < 10; i++) begin
            logic [1:0] op;
            op = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
            do_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                   ($urandom % 4) != 0);
        end
        summary();
    end
endmodule